// File: doc/BRIEF.md
# Self-Learning Walking-Pattern Continuity Tester

This block sequences a continuity check of a wiring harness whose pins are all bidirectional. For each of N steps it raises a walking vector on its drive outputs, waits a programmable number of settle cycles, and then takes the sensed N-bit response on the first cycle that the sense-valid input is high. The walking pattern is either a single high pin (walking ones) or a single released pin (walking zeros). A high drive bit means the pin is actively pulled high. A low bit means the pin is released to its pull-down, so pins that are shorted together can never fight.

A learn pass run on a known good harness records the response of every step in an N-entry by N-bit reference memory, indexed by step number. A test pass repeats the same sequence and compares each response with the stored entry. The first step whose response differs is latched, and `fail_o` is raised. The pass always runs to its last step, so `done_o` asserts whether the harness is good or bad. Because each step senses every pin, one pass catches a pin that fans out to several others as well as a group of pins tied together.

The controller has four states. IDLE waits for `start_i`. SETTLE drives the current vector and counts down the settle cycles. SAMPLE holds the vector until `sense_vld_i`. WRAP ends the pass. The transitions are: IDLE to SETTLE on an accepted start; IDLE to IDLE on a start that is refused for lack of a reference; SETTLE to SAMPLE when the settle counter is zero; SAMPLE to SETTLE on valid sense before the last step; SAMPLE to WRAP on valid sense at the last step; WRAP to IDLE.

Top module: `cltest_top`

## Requirements
- R1: With walking ones selected (`zeros_i`=0), step k drives `drive_o` with bit k high and every other bit low. Steps run in the order k = 0, 1, …, N-1.
- R2: With walking zeros selected (`zeros_i`=1), step k drives the bitwise inverse of the walking-ones vector for step k. Steps run in the same order.
- R3: Each step holds its vector for settle+1 cycles in SETTLE before the response can be taken. `sense_vld_i` has no effect during those cycles. With `sense_vld_i` held high, a pass keeps `busy_o` high for exactly N*(settle+2)+1 cycles.
- R4: A learn pass (`learn_i`=1) stores the response of each step as that step's reference. A following test pass on the same harness ends with `done_o`=1 and `fail_o`=0.
- R5: In a test pass, a response that differs from the stored entry sets `fail_o`. `fail_step_o` holds the index of the first differing step, and later mismatches do not change it.
- R6: A test pass always runs through all N steps and sets `done_o`, even after a mismatch. `done_o`, `fail_o` and `fail_step_o` hold until the next accepted start, which clears them.
- R7: A test start is refused when no learn pass has completed since reset, or when the completed learn pass used the other walking polarity. A refused start sets `no_ref_o` one cycle later, leaves `busy_o` low and `drive_o` zero, and runs no steps. The next start clears `no_ref_o`.
- R8: While no pass is running, `drive_o` is all zeros. A start request that arrives while a pass is running is ignored and does not change that pass's mode, polarity, length or result.
- R9: The reference memory is written only during learn passes. A test pass on a faulty harness leaves the reference unchanged, so a later test on the good harness passes.
- R10: After reset, `busy_o`, `done_o`, `fail_o` and `no_ref_o` are low, `drive_o` is zero, and no reference is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted in IDLE only |
| learn_i | input | 1 | 1 = learn pass, 0 = test pass; sampled at start |
| zeros_i | input | 1 | 1 = walking zeros, 0 = walking ones; sampled at start |
| settle_i | input | SETTLE_W | Settle cycles per step; sampled at start |
| drive_o | output | N_PINS | Drive vector; 1 = pull pin high, 0 = release |
| sense_i | input | N_PINS | Sensed pin levels |
| sense_vld_i | input | 1 | Sensed levels are valid this cycle |
| busy_o | output | 1 | A pass is running |
| done_o | output | 1 | The last pass completed; held until next start |
| fail_o | output | 1 | The last test pass saw a mismatch; held until next start |
| fail_step_o | output | IDX_W | Index of the first mismatching step |
| no_ref_o | output | 1 | The last test start was refused for lack of a matching reference |

## Verification
On every cycle, the assertions check the shape of the drive vector: one hot for walking ones, one cold for walking zeros, and quiet when idle. They also check that the step index stays in range, that SAMPLE is entered only through SETTLE, that the fail flag and the latched step hold during a pass, and that a refusal never coexists with a running pass. Only the bench scenarios can show the things that depend on what the harness answers. These are that a learned recording later matches the same harness, that a faulty harness yields the right first failing step in each polarity, and that test passes leave the reference intact. The bench scenarios also show the exact pass length for a chosen settle value, the refusal of a test when the learned polarity does not match, and that a start pulse arriving mid-pass has no effect.

// File: rtl/cltest_pkg.sv
package cltest_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_WRAP   = 2'd3
    } cl_state_e;

endpackage

// File: rtl/cltest_vecgen.sv
module cltest_vecgen #(
    parameter int N_PINS = 8,
    parameter int IDX_W  = 3
) (
    input  logic [IDX_W-1:0]  step_i,
    input  logic              zeros_i,
    output logic [N_PINS-1:0] vec_o
);
    // One comparator per pin; polarity flips the whole vector.
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        assign vec_o[g] = (step_i == IDX_W'(g)) ^ zeros_i;
    end
endmodule

// File: rtl/cltest_refmem.sv
module cltest_refmem #(
    parameter int N_PINS = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic [N_PINS-1:0] wdata_i,
    output logic [N_PINS-1:0] rdata_o
);
    logic [N_PINS-1:0] mem_q [N_PINS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

    // R9: every write lands on a real step entry
    a_r9_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(addr_i) < N_PINS));
endmodule

// File: rtl/cltest_top.sv
module cltest_top
    import cltest_pkg::*;
#(
    parameter int N_PINS   = 8,
    parameter int SETTLE_W = 8,
    localparam int IDX_W   = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                learn_i,
    input  logic                zeros_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic [N_PINS-1:0]   drive_o,
    input  logic [N_PINS-1:0]   sense_i,
    input  logic                sense_vld_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                fail_o,
    output logic [IDX_W-1:0]    fail_step_o,
    output logic                no_ref_o
);
    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(N_PINS - 1);

    cl_state_e           state_q, state_d;
    logic [IDX_W-1:0]    step_q;
    logic [SETTLE_W-1:0] cnt_q, settle_q;
    logic                learn_q, zeros_q;
    logic                done_q, fail_q, noref_q;
    logic [IDX_W-1:0]    fstep_q;
    logic                ref_valid_q, ref_zeros_q;

    logic                start_acc, ref_ok, may_run, accept, last_step, stepping;
    logic                mem_we, mismatch;
    logic [N_PINS-1:0]   vec, ref_vec;

    cltest_vecgen #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_vecgen (
        .step_i  (step_q),
        .zeros_i (zeros_q),
        .vec_o   (vec)
    );

    cltest_refmem #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_refmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .addr_i  (step_q),
        .wdata_i (sense_i),
        .rdata_o (ref_vec)
    );

    assign start_acc = (state_q == ST_IDLE) && start_i;
    assign ref_ok    = ref_valid_q && (ref_zeros_q == zeros_i);
    assign may_run   = learn_i || ref_ok;
    assign accept    = (state_q == ST_SAMPLE) && sense_vld_i;
    assign last_step = (step_q == LAST_STEP);
    assign mem_we    = accept && learn_q;
    assign mismatch  = (sense_i != ref_vec);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_acc && may_run) state_d = ST_SETTLE;
            ST_SETTLE: if (cnt_q == '0)          state_d = ST_SAMPLE;
            ST_SAMPLE: if (sense_vld_i)          state_d = last_step ? ST_WRAP : ST_SETTLE;
            ST_WRAP:                             state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Step, settle, result and reference bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q      <= '0;
            cnt_q       <= '0;
            settle_q    <= '0;
            learn_q     <= 1'b0;
            zeros_q     <= 1'b0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            noref_q     <= 1'b0;
            fstep_q     <= '0;
            ref_valid_q <= 1'b0;
            ref_zeros_q <= 1'b0;
        end else begin
            if (start_acc) begin
                done_q  <= 1'b0;
                fail_q  <= 1'b0;
                fstep_q <= '0;
                noref_q <= !may_run;
                if (may_run) begin
                    learn_q  <= learn_i;
                    zeros_q  <= zeros_i;
                    settle_q <= settle_i;
                    cnt_q    <= settle_i;
                    step_q   <= '0;
                    if (learn_i) ref_valid_q <= 1'b0;
                end
            end
            if (state_q == ST_SETTLE && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (accept) begin
                if (!learn_q && mismatch && !fail_q) begin
                    fail_q  <= 1'b1;
                    fstep_q <= step_q;
                end
                if (!last_step) begin
                    step_q <= step_q + 1'b1;
                    cnt_q  <= settle_q;
                end
            end
            if (state_q == ST_WRAP) begin
                done_q <= 1'b1;
                if (learn_q) begin
                    ref_valid_q <= 1'b1;
                    ref_zeros_q <= zeros_q;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        stepping    = (state_q == ST_SETTLE) || (state_q == ST_SAMPLE);
        drive_o     = stepping ? vec : '0;
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        fail_o      = fail_q;
        fail_step_o = fstep_q;
        no_ref_o    = noref_q;
    end

    // R1: walking ones drives exactly one pin high per step
    a_r1_walk_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !zeros_q) |-> ($countones(drive_o) == 1));
    // R1: step index never leaves the pin range
    a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(step_q) < N_PINS));
    // R2: walking zeros releases exactly one pin per step
    a_r2_walk_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && zeros_q) |-> ($countones(drive_o) == N_PINS - 1));
    // R3: responses are taken only after a settle phase
    a_r3_sample_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |-> ($past(state_q) == ST_SETTLE || $past(state_q) == ST_SAMPLE));
    // R5: the latched first failing step does not move during a pass
    a_r5_fstep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && busy_o) |=> $stable(fail_step_o));
    // R6: fail stays set once raised in a pass
    a_r6_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && busy_o) |=> fail_o);
    // R7: a refusal never coexists with a running pass
    a_r7_noref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        no_ref_o |-> !busy_o);
    // R8: pins are released while idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (drive_o == '0));
endmodule

// File: tb/cltest_top_tb_top.sv
module cltest_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int SW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, learn_i = 1'b0, zeros_i = 1'b0;
    logic [SW-1:0] settle_i = '0;
    logic [N-1:0]  drive_o, sense_i;
    logic          sense_vld_i = 1'b1;
    logic          busy_o, done_o, fail_o, no_ref_o;
    logic [IW-1:0] fail_step_o;

    int checks = 0;
    int errors = 0;
    int harness = 0;   // 0 good, 1 open 2-5, 2 extra short 4-6

    always #(CLK_PERIOD/2) clk = ~clk;

    cltest_top #(.N_PINS(N), .SETTLE_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .learn_i(learn_i),
        .zeros_i(zeros_i), .settle_i(settle_i), .drive_o(drive_o),
        .sense_i(sense_i), .sense_vld_i(sense_vld_i), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .fail_step_o(fail_step_o),
        .no_ref_o(no_ref_o)
    );

    function automatic logic [N-1:0] links(int pin, int h);
        logic [N-1:0] m = '0;
        m[pin] = 1'b1;
        if (h != 1) begin
            if (pin == 2) m[5] = 1'b1;
            if (pin == 5) m[2] = 1'b1;
        end
        if (pin == 1) m[3] = 1'b1;
        if (pin == 3) m[1] = 1'b1;
        if (h == 2) begin
            if (pin == 4) m[6] = 1'b1;
            if (pin == 6) m[4] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [N-1:0] respond(logic [N-1:0] d, int h);
        logic [N-1:0] s = '0;
        for (int i = 0; i < N; i++) if (d[i]) s |= links(i, h);
        return s;
    endfunction

    function automatic logic [N-1:0] walk(int k, logic z);
        logic [N-1:0] v = '0;
        v[k] = 1'b1;
        return z ? ~v : v;
    endfunction

    function automatic int first_diff(int h, logic z);
        for (int k = 0; k < N; k++)
            if (respond(walk(k, z), h) != respond(walk(k, z), 0)) return k;
        return -1;
    endfunction

    always_comb sense_i = respond(drive_o, harness);

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Runs one pass; optional start pulse injected mid-run.
    task automatic run(input logic lrn, input logic z, input int s, input bit inject,
                       output int busy_cnt, output bit order_ok);
        logic [N-1:0] prev = '0;
        int idx = 0;
        busy_cnt = 0;
        order_ok = 1'b1;
        @(negedge clk);
        learn_i = lrn; zeros_i = z; settle_i = SW'(s); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int g = 0; g < 5000; g++) begin
            if (!busy_o) break;
            busy_cnt++;
            if (drive_o != prev && drive_o != '0) begin
                if (idx >= N || drive_o != walk(idx, z)) order_ok = 1'b0;
                idx++;
            end
            prev = drive_o;
            if (inject && busy_cnt == 3) begin
                learn_i = ~lrn; zeros_i = ~z; settle_i = SW'(s + 3); start_i = 1'b1;
            end else begin
                start_i = 1'b0;
                learn_i = lrn; zeros_i = z;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        if (idx != N && busy_cnt != 0) order_ok = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !fail_o && !no_ref_o, "R10", "flags after reset",
            {busy_o, done_o, fail_o, no_ref_o}, 0);
        chk(drive_o == '0, "R10", "drive after reset", int'(drive_o), 0);
    endtask

    task automatic t_no_ref_after_reset();
        int b; bit o;
        harness = 0;
        run(1'b0, 1'b0, 1, 1'b0, b, o);
        chk(no_ref_o, "R7", "no_ref after unlearned test", no_ref_o, 1);
        chk(b == 0 && !done_o, "R7", "refused test ran cycles", b, 0);
        chk(drive_o == '0, "R7", "drive while refused", int'(drive_o), 0);
    endtask

    task automatic t_learn_ones();
        int b; bit o;
        harness = 0;
        run(1'b1, 1'b0, 2, 1'b0, b, o);
        chk(o, "R1", "walking ones order", o, 1);
        chk(b == N*4+1, "R3", "busy cycles settle 2", b, N*4+1);
        chk(done_o && !no_ref_o, "R4", "learn done, no_ref cleared", done_o, 1);
    endtask

    task automatic t_test_good(string req);
        int b; bit o;
        harness = 0;
        run(1'b0, 1'b0, 0, 1'b0, b, o);
        chk(b == N*2+1, "R3", "busy cycles settle 0", b, N*2+1);
        chk(done_o && !fail_o, req, "good harness passes", fail_o, 0);
    endtask

    task automatic t_test_bad(int h);
        int b; bit o;
        int exp = first_diff(h, 1'b0);
        harness = h;
        run(1'b0, 1'b0, 1, 1'b0, b, o);
        chk(fail_o, "R5", "fail on faulty harness", fail_o, 1);
        chk(int'(fail_step_o) == exp, "R5", "first failing step", int'(fail_step_o), exp);
        chk(done_o && b == N*3+1, "R6", "faulty pass runs to end", b, N*3+1);
        repeat (5) @(negedge clk);
        chk(fail_o && done_o && int'(fail_step_o) == exp, "R6", "results held while idle",
            int'(fail_step_o), exp);
        harness = 0;
    endtask

    task automatic t_polarity_refusal();
        int b; bit o;
        run(1'b0, 1'b1, 0, 1'b0, b, o);
        chk(no_ref_o && b == 0, "R7", "test with other polarity refused", no_ref_o, 1);
        chk(!done_o && !fail_o, "R6", "refused start cleared old results", {done_o, fail_o}, 0);
    endtask

    task automatic t_zeros();
        int b; bit o;
        int exp = first_diff(1, 1'b1);
        harness = 0;
        run(1'b1, 1'b1, 1, 1'b0, b, o);
        chk(o, "R2", "walking zeros order", o, 1);
        chk(done_o && b == N*3+1, "R2", "zeros learn length", b, N*3+1);
        harness = 1;
        run(1'b0, 1'b1, 0, 1'b0, b, o);
        chk(fail_o && int'(fail_step_o) == exp, "R5", "zeros first failing step",
            int'(fail_step_o), exp);
        harness = 0;
        run(1'b0, 1'b1, 0, 1'b0, b, o);
        chk(done_o && !fail_o, "R9", "zeros reference intact", fail_o, 0);
    endtask

    task automatic t_start_while_busy();
        int b; bit o;
        harness = 0;
        run(1'b0, 1'b1, 1, 1'b1, b, o);
        chk(b == N*3+1 && o, "R8", "mid-run start ignored: length", b, N*3+1);
        chk(done_o && !fail_o && !no_ref_o, "R8", "mid-run start ignored: result", fail_o, 0);
        run(1'b0, 1'b1, 0, 1'b0, b, o);
        chk(done_o && !fail_o, "R8", "reference unchanged after ignored learn start", fail_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_ref_after_reset();
        t_learn_ones();
        t_test_good("R4");
        t_test_bad(1);
        t_test_good("R9");
        t_test_bad(2);
        t_polarity_refusal();
        t_zeros();
        t_start_while_busy();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule